// File: doc/BRIEF.md
# Sixteen-Colour Lookup Palette with Host Bypass

This block is a small colour lookup table that sits between a pixel source and the video output. Software loads it through 16-bit I/O writes. The low address byte selects the board. Bits of the high address byte carry the entry number and a flag that says which colour components the write loads. The data byte carries the 4-bit component values.

Each entry holds a 4-bit red, a 4-bit green and a 4-bit blue value. One write with the flag clear loads blue and red together. A second write with the flag set loads green on its own. There is no way to read the table back.

On every clock a 4-bit pixel index is looked up and a registered 12-bit colour is driven out. An external select bit routes either this palette colour or the host's own 12-bit colour to the output. Video timing and digital-to-analogue conversion sit outside this block.

Top module: `palette_board`

## Requirements
- R1: After reset, entry n holds red = green = blue = n for every n from 0 to 15, and `rgb_out` is 0.
- R2: A write (`io_wr` = 1) with `io_addr[7:0]` = 8'hAE, `io_addr[15:13]` = 0 and `io_addr[8]` = 0 sets the blue value of entry `io_addr[12:9]` to `io_data[3:0]` and its red value to `io_data[7:4]`. The green value of that entry is left unchanged.
- R3: A write with `io_addr[8]` = 1 and an otherwise valid address sets the green value of entry `io_addr[12:9]` to `io_data[3:0]`. `io_data[7:4]` is ignored, and red and blue are left unchanged.
- R4: A write whose `io_addr[15:13]` is nonzero changes no entry.
- R5: A write whose `io_addr[7:0]` differs from 8'hAE changes no entry, and neither does any cycle with `io_wr` = 0.
- R6: With `use_host` = 0, the colour of entry `pix_idx` appears on `rgb_out` one clock later, packed as {red[11:8], green[7:4], blue[3:0]}.
- R7: With `use_host` = 1, `host_rgb` appears on `rgb_out` one clock later, and the palette contents have no effect on the output.
- R8: A lookup of an entry in the same cycle as a write to that entry returns the old contents. The new contents show on the next lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | Full I/O address: [7:0] port, [8] component flag, [12:9] entry, [15:13] must be zero |
| io_data | input | 8 | Write data: [3:0] blue or green, [7:4] red |
| pix_idx | input | 4 | Pixel index to look up |
| host_rgb | input | 12 | Host's direct colour, {R,G,B} |
| use_host | input | 1 | 0 routes the palette colour, 1 routes the host colour |
| rgb_out | output | 12 | Registered colour output {R,G,B} |

## Verification
The embedded assertions check on every cycle:
- that the two component strobes are never active together;
- that no strobe fires for a wrong port byte or a nonzero high address field;
- that each strobe loads only its own components and keeps the others stable;
- that an idle cycle leaves the table untouched;
- that the output follows the chosen source with one clock of delay.

Only the bench scenarios can show the remaining behaviour. These are the grey-ramp contents after reset, the exact field positions in the address and data words, and old-data behaviour when a lookup and a write meet. Random sequences checked against a reference table show that sequences of mixed valid and rejected writes leave exactly the expected colours.

// File: rtl/palw_pkg.sv
package palw_pkg;

   // component flag carried in the address
   typedef enum logic {
      CSEL_BLUE_RED = 1'b0,
      CSEL_GREEN    = 1'b1
   } csel_e;

   // reset value of a component: entry index truncated to component width
   function automatic logic [7:0] ramp_value(input int unsigned entry);
      return entry[7:0];
   endfunction

endpackage

// File: rtl/palw_decode.sv
module palw_decode
   import palw_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8,
   parameter int IDX_W   = 4,
   parameter logic [PORT_W-1:0] PORT_ID = 8'hAE
) (
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              we_br,
   output logic              we_g,
   output logic [IDX_W-1:0]  wr_idx
);
   localparam int SEL_BIT = PORT_W;
   localparam int IDX_LSB = SEL_BIT + 1;
   localparam int HI_LSB  = IDX_LSB + IDX_W;

   if (HI_LSB > ADDR_W) begin : g_bad_width
      $error("palw_decode: address too narrow for port, flag and index");
   end

   logic  port_hit;
   logic  hi_zero;
   csel_e csel;

   assign port_hit = (io_addr[PORT_W-1:0] == PORT_ID);
   assign csel     = csel_e'(io_addr[SEL_BIT]);
   assign wr_idx   = io_addr[IDX_LSB +: IDX_W];

   if (HI_LSB < ADDR_W) begin : g_hi_field
      assign hi_zero = (io_addr[ADDR_W-1:HI_LSB] == '0);
   end else begin : g_no_hi_field
      assign hi_zero = 1'b1;
   end

   logic accept;
   assign accept = io_wr & port_hit & hi_zero;
   assign we_br  = accept & (csel == CSEL_BLUE_RED);
   assign we_g   = accept & (csel == CSEL_GREEN);

   // strobes are mutually exclusive
   always_comb begin
      if (we_br || we_g) begin
         p_one_strobe_r3: assert ($onehot0({we_br, we_g}));
         p_port_match_r5: assert (io_wr && io_addr[PORT_W-1:0] == PORT_ID);
      end
   end

   if (HI_LSB < ADDR_W) begin : g_hi_check
      always_comb begin
         if (we_br || we_g) begin
            p_high_zero_r4: assert (io_addr[ADDR_W-1:HI_LSB] == '0);
         end
      end
   end
endmodule

// File: rtl/palw_store.sv
module palw_store
   import palw_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int COMP_W = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  we_br,
   input  logic                                  we_g,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [2*COMP_W-1:0]                   wr_data,
   output logic [(1<<IDX_W)-1:0][3*COMP_W-1:0]   table_q
);
   localparam int ENTRIES = 1 << IDX_W;

   if (ENTRIES > (1 << COMP_W)) begin : g_bad_ramp
      $error("palw_store: grey ramp needs as many component codes as entries");
   end
   if (COMP_W > 8) begin : g_bad_comp
      $error("palw_store: component width above 8 not supported");
   end

   logic [ENTRIES-1:0][COMP_W-1:0] r_q, g_q, b_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      localparam logic [7:0] RAMP = ramp_value(e);
      logic [COMP_W-1:0] r_e, g_e, b_e;
      logic hit;
      assign hit = (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_e <= RAMP[COMP_W-1:0];
            g_e <= RAMP[COMP_W-1:0];
            b_e <= RAMP[COMP_W-1:0];
         end else begin
            if (we_br && hit) begin
               b_e <= wr_data[COMP_W-1:0];
               r_e <= wr_data[2*COMP_W-1:COMP_W];
            end
            if (we_g && hit) begin
               g_e <= wr_data[COMP_W-1:0];
            end
         end
      end

      assign r_q[e]     = r_e;
      assign g_q[e]     = g_e;
      assign b_q[e]     = b_e;
      assign table_q[e] = {r_e, g_e, b_e};
   end

   p_br_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_br |=> (b_q[$past(wr_idx)] == $past(wr_data[COMP_W-1:0])) &&
                (r_q[$past(wr_idx)] == $past(wr_data[2*COMP_W-1:COMP_W])));

   p_green_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_br && !we_g) |=> g_q[$past(wr_idx)] == $past(g_q[wr_idx]));

   p_g_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_g |=> g_q[$past(wr_idx)] == $past(wr_data[COMP_W-1:0]));

   p_br_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_g && !we_br) |=> (r_q[$past(wr_idx)] == $past(r_q[wr_idx])) &&
                           (b_q[$past(wr_idx)] == $past(b_q[wr_idx])));

   p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_br || we_g) |=> $stable(table_q));
endmodule

// File: rtl/palw_lookup.sv
module palw_lookup #(
   parameter int IDX_W  = 4,
   parameter int COMP_W = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [(1<<IDX_W)-1:0][3*COMP_W-1:0]   table_q,
   input  logic [IDX_W-1:0]                      pix_idx,
   input  logic [3*COMP_W-1:0]                   host_rgb,
   input  logic                                  use_host,
   output logic [3*COMP_W-1:0]                   rgb_out
);
   localparam int RGB_W = 3 * COMP_W;

   logic [RGB_W-1:0] pal_rgb;
   assign pal_rgb = table_q[pix_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) rgb_out <= '0;
      else        rgb_out <= use_host ? host_rgb : pal_rgb;
   end

   p_palette_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !use_host |=> rgb_out == $past(table_q[pix_idx]));

   p_host_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
      use_host |=> rgb_out == $past(host_rgb));
endmodule

// File: rtl/palette_board.sv
module palette_board #(
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8,
   parameter int IDX_W   = 4,
   parameter int COMP_W  = 4,
   parameter logic [PORT_W-1:0] PORT_ID = 8'hAE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                io_wr,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic [2*COMP_W-1:0] io_data,
   input  logic [IDX_W-1:0]    pix_idx,
   input  logic [3*COMP_W-1:0] host_rgb,
   input  logic                use_host,
   output logic [3*COMP_W-1:0] rgb_out
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int RGB_W   = 3 * COMP_W;

   logic                           we_br, we_g;
   logic [IDX_W-1:0]               wr_idx;
   logic [ENTRIES-1:0][RGB_W-1:0]  table_q;

   palw_decode #(
      .ADDR_W (ADDR_W),
      .PORT_W (PORT_W),
      .IDX_W  (IDX_W),
      .PORT_ID(PORT_ID)
   ) u_decode (
      .io_wr  (io_wr),
      .io_addr(io_addr),
      .we_br  (we_br),
      .we_g   (we_g),
      .wr_idx (wr_idx)
   );

   palw_store #(
      .IDX_W (IDX_W),
      .COMP_W(COMP_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_br  (we_br),
      .we_g   (we_g),
      .wr_idx (wr_idx),
      .wr_data(io_data),
      .table_q(table_q)
   );

   palw_lookup #(
      .IDX_W (IDX_W),
      .COMP_W(COMP_W)
   ) u_lookup (
      .clk     (clk),
      .rst_n   (rst_n),
      .table_q (table_q),
      .pix_idx (pix_idx),
      .host_rgb(host_rgb),
      .use_host(use_host),
      .rgb_out (rgb_out)
   );

   p_reset_black_r1: assert property (@(posedge clk)
      !rst_n |=> rgb_out == '0);
endmodule

// File: tb/tb_palette_board.sv
module tb_palette_board;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_data = '0;
   logic [3:0]  pix_idx = '0;
   logic [11:0] host_rgb = '0;
   logic        use_host = 1'b0;
   logic [11:0] rgb_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [3:0] mr [16];
   logic [3:0] mg [16];
   logic [3:0] mb [16];

   always #10 clk = ~clk;

   palette_board dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_data(io_data), .pix_idx(pix_idx), .host_rgb(host_rgb),
      .use_host(use_host), .rgb_out(rgb_out)
   );

   function automatic logic [11:0] exp_rgb(input logic [3:0] i);
      return {mr[i], mg[i], mb[i]};
   endfunction

   function automatic logic [15:0] mk_addr(input logic [3:0] idx, input logic sel);
      return {3'b000, idx, sel, 8'hAE};
   endfunction

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rgb_out=%h expected %h", req, act, exp);
      end
   endtask

   // apply model effect of a write (R2..R5)
   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      if (a[7:0] == 8'hAE && a[15:13] == 3'b000) begin
         if (a[8] == 1'b0) begin
            mb[a[12:9]] = d[3:0];
            mr[a[12:9]] = d[7:4];
         end else begin
            mg[a[12:9]] = d[3:0];
         end
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_data = d;
      @(negedge clk);
      io_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic look(input string req, input logic [3:0] i);
      @(negedge clk);
      use_host = 1'b0; pix_idx = i;
      @(negedge clk);
      check(req, rgb_out, exp_rgb(i));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) begin
         mr[i] = 4'(i); mg[i] = 4'(i); mb[i] = 4'(i);
      end
      repeat (3) @(negedge clk);
      check("R1 reset output", rgb_out, 12'h000);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) look("R1 grey ramp", 4'(i));

      // R2: blue/red load leaves green
      do_write(mk_addr(4'd3, 1'b0), 8'hA5);
      look("R2 blue-red load", 4'd3);
      // R3: green load ignores upper nibble, keeps red/blue
      do_write(mk_addr(4'd3, 1'b1), 8'hF9);
      look("R3 green load", 4'd3);
      do_write(mk_addr(4'd15, 1'b1), 8'h0C);
      look("R3 green entry 15", 4'd15);
      // R4: high bits nonzero ignored
      do_write({3'b100, 4'd7, 1'b0, 8'hAE}, 8'h11);
      look("R4 high field ignored", 4'd7);
      do_write({3'b001, 4'd7, 1'b1, 8'hAE}, 8'h0E);
      look("R4 high field ignored", 4'd7);
      // R5: wrong port byte ignored
      do_write({3'b000, 4'd8, 1'b0, 8'hAF}, 8'h33);
      look("R5 wrong port ignored", 4'd8);
      // R5: address and data presented without strobe
      @(negedge clk);
      io_wr = 1'b0; io_addr = mk_addr(4'd9, 1'b0); io_data = 8'h77;
      @(negedge clk);
      look("R5 no strobe ignored", 4'd9);

      // R7: host path, palette irrelevant
      @(negedge clk);
      use_host = 1'b1; host_rgb = 12'h5A3; pix_idx = 4'd3;
      @(negedge clk);
      check("R7 host path", rgb_out, 12'h5A3);
      host_rgb = 12'hC01;
      @(negedge clk);
      check("R7 host path follows", rgb_out, 12'hC01);
      // R6: back to palette, one-clock latency
      use_host = 1'b0; pix_idx = 4'd3;
      @(negedge clk);
      check("R6 palette path", rgb_out, exp_rgb(4'd3));

      // R8: lookup and write to same entry in same cycle
      pix_idx = 4'd5;
      io_wr = 1'b1; io_addr = mk_addr(4'd5, 1'b0); io_data = 8'h2D;
      @(negedge clk);
      io_wr = 1'b0;
      check("R8 old data on collision", rgb_out, exp_rgb(4'd5));
      model_write(mk_addr(4'd5, 1'b0), 8'h2D);
      @(negedge clk);
      check("R8 new data next lookup", rgb_out, exp_rgb(4'd5));

      // random mix of valid and rejected writes with lookups (R2..R7)
      for (int k = 0; k < 400; k++) begin
         logic [15:0] a;
         logic [7:0]  d;
         int c;
         c = $urandom_range(0, 9);
         a = mk_addr(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         d = 8'($urandom);
         if (c == 0) a[15:13] = 3'($urandom_range(1, 7));
         if (c == 1) a[7:0]   = 8'hAE ^ 8'($urandom_range(1, 255));
         do_write(a, d);
         if ($urandom_range(0, 3) == 0) begin
            logic [11:0] h;
            h = 12'($urandom);
            @(negedge clk);
            use_host = 1'b1; host_rgb = h; pix_idx = 4'($urandom_range(0, 15));
            @(negedge clk);
            check("R7 random host", rgb_out, h);
            use_host = 1'b0;
         end else begin
            look("R6 random lookup", 4'($urandom_range(0, 15)));
         end
      end
      for (int i = 0; i < 16; i++) look("R2 R3 final table", 4'(i));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule